// File: doc/BRIEF.md
# Radio Operating-Mode Controller with Automatic Exit

This block holds the three enable bits that set a packet radio's operating mode: synthesizer enable, receive enable and transmit enable. It turns them into one of four operating states and latches the packet-handler events as interrupt flags. When buffered packet data feeds the modulator, the block ends a transmission or a reception by itself. A sent packet drops the transmit enable and a valid received packet drops the receive enable. The bits still set afterwards decide where the radio lands, so a host that left the synthesizer enabled finds the radio in Tune and not Idle.

Receive faults (bad checksum, bad header, missing sync word) only raise flags. Reception keeps running until the host steps in. When the modulator is fed from a pin or from the internal pseudo-random source, no event touches the enable bits. The host then stops transmit or receive itself with a register write. The host clears the flags by reading status. An active-low interrupt line follows the flags that are enabled.

Top module: `radio_mode_ctrl`

## Requirements
- R1: After reset the mode register is 3'b000, the state is Idle (2'd0), all flags are 0 and `irq_n` is 1.
- R2: A host write loads `wr_data` into `mode_q` at the next clock edge. Bit 0 is synthesizer enable, bit 1 is receive enable and bit 2 is transmit enable. `state` is 2'd3 (TX) when bit 2 is set, else 2'd2 (RX) when bit 1 is set, else 2'd1 (Tune) when bit 0 is set, else 2'd0 (Idle).
- R3: Take `src_sel` equal to `FIFO_SRC` (default 2'd2) with bit 2 of the mode set. A packet-sent pulse then clears bit 2 at the next edge and keeps the other bits. With bit 0 set the state becomes Tune.
- R4: When bit 2 is the only set bit, a packet-sent pulse in buffered mode returns the state to Idle.
- R5: In buffered mode, with bit 1 set, a packet-valid pulse clears bit 1 at the next edge and keeps the other bits.
- R6: Checksum, header and sync error pulses never change `mode_q`. Receive stays active.
- R7: When `src_sel` differs from `FIFO_SRC`, neither event changes `mode_q`. Transmit and receive stay enabled until the host writes.
- R8: A host write in the same cycle as an automatic clear loads the written value, except that the bit being auto-cleared ends up 0.
- R9: Each event sets its flag in `irq_flags` at the next edge: bit 0 sent, bit 1 valid, bit 2 checksum, bit 3 header, bit 4 sync. The flag stays set until a `status_rd` cycle clears all flags. An event in the read cycle leaves its flag set.
- R10: `irq_n` is 0 exactly when some flag is set whose bit in `irq_en` is 1.
- R11: A packet-sent or packet-valid pulse while the matching enable bit is clear leaves `mode_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the mode register |
| wr_data | input | 3 | Value to write: {tx_en, rx_en, pll_en} |
| src_sel | input | SRC_W | Modulation data source select |
| ev_pkt_sent | input | 1 | Packet transmitted pulse |
| ev_pkt_valid | input | 1 | Valid packet received pulse |
| ev_crc_err | input | 1 | Checksum error pulse |
| ev_hdr_err | input | 1 | Header mismatch pulse |
| ev_sync_err | input | 1 | Sync word error pulse |
| status_rd | input | 1 | Host status read; clears the flags |
| irq_en | input | 5 | Per-flag interrupt enable |
| mode_q | output | 3 | Mode register contents |
| state | output | 2 | Operating state: 0 Idle, 1 Tune, 2 RX, 3 TX |
| irq_flags | output | 5 | Sticky event flags |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Every stored bit of this block is visible at its ports. A wrongly cleared or kept enable bit shows on `mode_q` and `state` one edge after the pulse that caused it. A lost or stale flag shows on `irq_flags` and `irq_n` one edge after the event or the status read. The directed cases therefore sample one cycle after each stimulus. They aim at the spots where a slip stays hidden: fallback to Tune versus Idle, the non-buffered sources, a write racing an automatic clear, and an event racing a status read.

// File: rtl/rmc_pkg.sv
`timescale 1ns/1ps
package rmc_pkg;
   typedef enum logic [1:0] {
      RS_IDLE = 2'd0,
      RS_TUNE = 2'd1,
      RS_RX   = 2'd2,
      RS_TX   = 2'd3
   } radio_state_e;

   localparam int MODE_W  = 3;
   localparam int MB_PLL  = 0;
   localparam int MB_RX   = 1;
   localparam int MB_TX   = 2;

   localparam int NUM_EV   = 5;
   localparam int EV_SENT  = 0;
   localparam int EV_VALID = 1;
   localparam int EV_CRC   = 2;
   localparam int EV_HDR   = 3;
   localparam int EV_SYNC  = 4;
endpackage

// File: rtl/rmc_mode_reg.sv
`timescale 1ns/1ps
module rmc_mode_reg
   import rmc_pkg::*;
#(
   parameter int SRC_W    = 2,
   parameter int FIFO_SRC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_data,
   input  logic [SRC_W-1:0]  src_sel,
   input  logic              ev_sent,
   input  logic              ev_valid,
   output logic [MODE_W-1:0] mode_q
);
   localparam logic [SRC_W-1:0] FIFO_CODE = SRC_W'(FIFO_SRC);

   logic              buffered;
   logic              clr_tx;
   logic              clr_rx;
   logic [MODE_W-1:0] mode_nxt;

   assign buffered = (src_sel == FIFO_CODE);
   assign clr_tx   = buffered & ev_sent  & mode_q[MB_TX];
   assign clr_rx   = buffered & ev_valid & mode_q[MB_RX];

   always_comb begin
      mode_nxt = wr_en ? wr_data : mode_q;
      if (clr_tx) mode_nxt[MB_TX] = 1'b0;
      if (clr_rx) mode_nxt[MB_RX] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= '0;
      else        mode_q <= mode_nxt;
   end
endmodule

// File: rtl/rmc_state_dec.sv
`timescale 1ns/1ps
module rmc_state_dec
   import rmc_pkg::*;
(
   input  logic [MODE_W-1:0] mode_q,
   output radio_state_e      state
);
   always_comb begin
      if (mode_q[MB_TX])       state = RS_TX;
      else if (mode_q[MB_RX])  state = RS_RX;
      else if (mode_q[MB_PLL]) state = RS_TUNE;
      else                     state = RS_IDLE;
   end
endmodule

// File: rtl/rmc_irq_latch.sv
`timescale 1ns/1ps
module rmc_irq_latch #(
   parameter int N       = 5,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic         rd_clr,
   input  logic [N-1:0] en,
   output logic [N-1:0] flags,
   output logic         irq_n
);
   logic pending;

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flags[i] <= 1'b0;
         else if (ev[i])  flags[i] <= 1'b1;
         else if (rd_clr) flags[i] <= 1'b0;
      end
   end

   assign pending = |(flags & en);

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_n <= 1'b1;
         else        irq_n <= ~pending;
      end
   end else begin : g_irq_comb
      assign irq_n = ~pending;
   end
endmodule

// File: rtl/radio_mode_ctrl.sv
`timescale 1ns/1ps
module radio_mode_ctrl
   import rmc_pkg::*;
#(
   parameter int SRC_W    = 2,
   parameter int FIFO_SRC = 2,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [MODE_W-1:0]  wr_data,
   input  logic [SRC_W-1:0]   src_sel,
   input  logic               ev_pkt_sent,
   input  logic               ev_pkt_valid,
   input  logic               ev_crc_err,
   input  logic               ev_hdr_err,
   input  logic               ev_sync_err,
   input  logic               status_rd,
   input  logic [NUM_EV-1:0]  irq_en,
   output logic [MODE_W-1:0]  mode_q,
   output logic [1:0]         state,
   output logic [NUM_EV-1:0]  irq_flags,
   output logic               irq_n
);
   if (SRC_W < 1) begin : g_bad_w
      $error("radio_mode_ctrl: SRC_W must be at least 1");
   end
   if (FIFO_SRC < 0 || FIFO_SRC >= (1 << SRC_W)) begin : g_bad_src
      $error("radio_mode_ctrl: FIFO_SRC does not fit in SRC_W bits");
   end

   logic [NUM_EV-1:0] ev_vec;
   radio_state_e      state_e;

   always_comb begin
      ev_vec           = '0;
      ev_vec[EV_SENT]  = ev_pkt_sent;
      ev_vec[EV_VALID] = ev_pkt_valid;
      ev_vec[EV_CRC]   = ev_crc_err;
      ev_vec[EV_HDR]   = ev_hdr_err;
      ev_vec[EV_SYNC]  = ev_sync_err;
   end

   rmc_mode_reg #(.SRC_W(SRC_W), .FIFO_SRC(FIFO_SRC)) mode_reg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .src_sel  (src_sel),
      .ev_sent  (ev_pkt_sent),
      .ev_valid (ev_pkt_valid),
      .mode_q   (mode_q)
   );

   rmc_state_dec state_dec_i (
      .mode_q (mode_q),
      .state  (state_e)
   );
   assign state = state_e;

   rmc_irq_latch #(.N(NUM_EV), .IRQ_REG(IRQ_REG)) irq_latch_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev_vec),
      .rd_clr (status_rd),
      .en     (irq_en),
      .flags  (irq_flags),
      .irq_n  (irq_n)
   );
endmodule

// File: rtl/rmc_chk.sv
`timescale 1ns/1ps
module rmc_chk
   import rmc_pkg::*;
#(
   parameter int SRC_W    = 2,
   parameter int FIFO_SRC = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [MODE_W-1:0] wr_data,
   input logic [SRC_W-1:0]  src_sel,
   input logic              ev_pkt_sent,
   input logic              ev_pkt_valid,
   input logic              ev_crc_err,
   input logic              ev_hdr_err,
   input logic              ev_sync_err,
   input logic [MODE_W-1:0] mode_q,
   input logic [NUM_EV-1:0] irq_flags
);
   logic              fifo_sel;
   logic [NUM_EV-1:0] evs;
   assign fifo_sel = (src_sel == SRC_W'(FIFO_SRC));
   assign evs = {ev_sync_err, ev_hdr_err, ev_crc_err, ev_pkt_valid, ev_pkt_sent};

   // R2
   host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !ev_pkt_sent && !ev_pkt_valid) |=> (mode_q == $past(wr_data)));

   // R3
   tx_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_sel && ev_pkt_sent && mode_q[MB_TX]) |=> !mode_q[MB_TX]);

   // R5
   rx_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_sel && ev_pkt_valid && mode_q[MB_RX]) |=> !mode_q[MB_RX]);

   // R6
   rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_crc_err || ev_hdr_err || ev_sync_err) && !ev_pkt_valid && !wr_en && mode_q[MB_RX])
      |=> mode_q[MB_RX]);

   // R7
   direct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_sel && !wr_en) |=> (mode_q == $past(mode_q)));

   // R9
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evs != '0) |=> ((irq_flags & $past(evs)) == $past(evs)));
endmodule

bind radio_mode_ctrl rmc_chk #(.SRC_W(SRC_W), .FIFO_SRC(FIFO_SRC)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_data      (wr_data),
   .src_sel      (src_sel),
   .ev_pkt_sent  (ev_pkt_sent),
   .ev_pkt_valid (ev_pkt_valid),
   .ev_crc_err   (ev_crc_err),
   .ev_hdr_err   (ev_hdr_err),
   .ev_sync_err  (ev_sync_err),
   .mode_q       (mode_q),
   .irq_flags    (irq_flags)
);

// File: tb/radio_mode_ctrl_tb.sv
`timescale 1ns/1ps
module radio_mode_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_data = '0;
   logic [1:0] src_sel = 2'd2;
   logic       ev_pkt_sent = 1'b0;
   logic       ev_pkt_valid = 1'b0;
   logic       ev_crc_err = 1'b0;
   logic       ev_hdr_err = 1'b0;
   logic       ev_sync_err = 1'b0;
   logic       status_rd = 1'b0;
   logic [4:0] irq_en = 5'b11111;
   logic [2:0] mode_q;
   logic [1:0] state;
   logic [4:0] irq_flags;
   logic       irq_n;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   radio_mode_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .src_sel(src_sel), .ev_pkt_sent(ev_pkt_sent), .ev_pkt_valid(ev_pkt_valid),
      .ev_crc_err(ev_crc_err), .ev_hdr_err(ev_hdr_err), .ev_sync_err(ev_sync_err),
      .status_rd(status_rd), .irq_en(irq_en), .mode_q(mode_q), .state(state),
      .irq_flags(irq_flags), .irq_n(irq_n)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input int act, input int exp, input string req);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FIAL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] v);
      wr_en = 1'b1; wr_data = v;
      step();
      wr_en = 1'b0;
   endtask

   task automatic clear_flags();
      status_rd = 1'b1;
      step();
      status_rd = 1'b0;
   endtask

   task automatic t_reset();
      chk(mode_q, 0, "R1 mode");
      chk(state, 0, "R1 state");
      chk(irq_flags, 0, "R1 flags");
      chk(irq_n, 1, "R1 irq_n");
   endtask

   task automatic t_priority();
      wr(3'b111); chk(mode_q, 7, "R2 load"); chk(state, 3, "R2 tx prio");
      wr(3'b011); chk(state, 2, "R2 rx prio");
      wr(3'b001); chk(state, 1, "R2 tune");
      wr(3'b000); chk(state, 0, "R2 idle");
   endtask

   task automatic t_tx_tune();
      src_sel = 2'd2;
      wr(3'b101);
      ev_pkt_sent = 1'b1; step(); ev_pkt_sent = 1'b0;
      chk(mode_q, 1, "R3 mode after sent");
      chk(state, 1, "R3 tune fallback");
      clear_flags();
   endtask

   task automatic t_tx_idle();
      wr(3'b100);
      ev_pkt_sent = 1'b1; step(); ev_pkt_sent = 1'b0;
      chk(mode_q, 0, "R4 mode");
      chk(state, 0, "R4 idle fallback");
      clear_flags();
   endtask

   task automatic t_rx_exit();
      wr(3'b011);
      ev_pkt_valid = 1'b1; step(); ev_pkt_valid = 1'b0;
      chk(mode_q, 1, "R5 mode after valid");
      chk(state, 1, "R5 state");
      clear_flags();
   endtask

   task automatic t_rx_errors();
      wr(3'b010);
      ev_crc_err = 1'b1; step(); ev_crc_err = 1'b0;
      ev_hdr_err = 1'b1; step(); ev_hdr_err = 1'b0;
      ev_sync_err = 1'b1; step(); ev_sync_err = 1'b0;
      chk(mode_q, 2, "R6 rx kept");
      chk(state, 2, "R6 still RX");
      chk(irq_flags, 5'b11100, "R9 error flags");
      clear_flags();
   endtask

   task automatic t_direct();
      src_sel = 2'd0;
      wr(3'b100);
      ev_pkt_sent = 1'b1; step(); ev_pkt_sent = 1'b0;
      chk(mode_q, 4, "R7 tx kept src0");
      src_sel = 2'd1;
      wr(3'b010);
      ev_pkt_valid = 1'b1; step(); ev_pkt_valid = 1'b0;
      chk(mode_q, 2, "R7 rx kept src1");
      src_sel = 2'd3;
      wr(3'b110);
      ev_pkt_sent = 1'b1; ev_pkt_valid = 1'b1; step();
      ev_pkt_sent = 1'b0; ev_pkt_valid = 1'b0;
      chk(mode_q, 6, "R7 kept src3");
      src_sel = 2'd2;
      clear_flags();
   endtask

   task automatic t_collision();
      wr(3'b100);
      wr_en = 1'b1; wr_data = 3'b111; ev_pkt_sent = 1'b1;
      step();
      wr_en = 1'b0; ev_pkt_sent = 1'b0;
      chk(mode_q, 3, "R8 autoclear wins");
      chk(state, 2, "R8 state");
      clear_flags();
   endtask

   task automatic t_flags();
      wr(3'b000);
      ev_pkt_sent = 1'b1; step(); ev_pkt_sent = 1'b0;
      chk(irq_flags, 1, "R9 set");
      step();
      chk(irq_flags, 1, "R9 sticky");
      clear_flags();
      chk(irq_flags, 0, "R9 read clears");
      ev_hdr_err = 1'b1; step(); ev_hdr_err = 1'b0;
      status_rd = 1'b1; ev_crc_err = 1'b1; step();
      status_rd = 1'b0; ev_crc_err = 1'b0;
      chk(irq_flags, 5'b00100, "R9 event beats read");
      clear_flags();
   endtask

   task automatic t_irq();
      irq_en = 5'b00100;
      ev_pkt_sent = 1'b1; step(); ev_pkt_sent = 1'b0;
      chk(irq_n, 1, "R10 masked flag");
      ev_crc_err = 1'b1; step(); ev_crc_err = 1'b0;
      chk(irq_n, 0, "R10 enabled flag");
      clear_flags();
      chk(irq_n, 1, "R10 released");
      irq_en = 5'b11111;
   endtask

   task automatic t_no_target();
      wr(3'b001);
      ev_pkt_sent = 1'b1; step(); ev_pkt_sent = 1'b0;
      chk(mode_q, 1, "R11 sent w/o tx");
      wr(3'b100);
      ev_pkt_valid = 1'b1; step(); ev_pkt_valid = 1'b0;
      chk(mode_q, 4, "R11 valid w/o rx");
      clear_flags();
   endtask

   initial begin
      #(20 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_priority();
      t_tx_tune();
      t_tx_idle();
      t_rx_exit();
      t_rx_errors();
      t_direct();
      t_collision();
      t_flags();
      t_irq();
      t_no_target();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule